// File: doc/BRIEF.md
# Receive Buffer Descriptor Sequencer

This block takes a stream of received characters and places them in memory buffers arranged as a ring of eight descriptors. Each descriptor has a base address, a buffer length, an empty flag, an interrupt-enable flag, a continuous-mode flag and a running received count. A host loads descriptors through a write port. The sequencer writes each accepted character to `base + count` through a simple memory write port.

When a buffer reaches its length, the sequencer closes it. It reports the descriptor index, the byte count and the final empty flag on a one-cycle update port, and then moves to the next descriptor in the ring. A non-continuous buffer has its empty flag cleared on close. A continuous buffer keeps the flag set, so the same buffer is refilled on every lap of the ring.

A character that arrives while the current descriptor is not empty is dropped. The drop sets a sticky overrun flag. Buffer completion raises a level interrupt when the descriptor asks for one. A single clear input releases both the interrupt and the overrun flag.

Top module: `rx_bd_seq`

## Requirements
- R1: A character with `rx_valid_i` high, while the current descriptor's empty flag is 1, is written to address `base + received_count` with its data. `mem_we_o` pulses for exactly one cycle, in the cycle after the input cycle.
- R2: The character that brings the received count up to the buffer length closes the buffer. In the next cycle `bd_upd_o` pulses with the descriptor index and a count equal to the length. The descriptor's received count returns to 0.
- R3: A close raises `irq_o` only when the closed descriptor's interrupt flag is 1. `irq_o` then stays high until a cycle with `clr_i` high.
- R4: After a close the current index advances by one, and index 7 wraps to 0. The next character goes to the next descriptor's base address, even when it arrives in the very next cycle.
- R5: On close, a descriptor with continuous mode 0 gets its empty flag cleared, and the update port reports empty = 0. With continuous mode 1 the flag stays 1, the update port reports empty = 1, and the buffer is refilled from its base on the next lap.
- R6: A character that arrives while the current descriptor's empty flag is 0 is dropped: no memory write, no update pulse, and no change of index. It sets `overrun_o` in the next cycle, and `overrun_o` stays high until `clr_i`.
- R7: A host write loads all fields of the addressed descriptor and resets its received count to 0. The new values apply from the next character.
- R8: After reset all descriptors have empty flag 0, the index is 0, and `mem_we_o`, `bd_upd_o`, `irq_o` and `overrun_o` are 0.
- R9: If `clr_i` is high in the same cycle as a close that sets the interrupt, `irq_o` is 1 afterwards. A clear with no new event lowers both `irq_o` and `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received character valid |
| rx_data_i | input | DATA_W | Received character |
| host_we_i | input | 1 | Descriptor load strobe |
| host_idx_i | input | IDX_W | Descriptor index to load |
| host_empty_i | input | 1 | Empty flag to load |
| host_int_i | input | 1 | Interrupt-enable flag to load |
| host_cont_i | input | 1 | Continuous-mode flag to load |
| host_len_i | input | LEN_W | Buffer length to load |
| host_base_i | input | ADDR_W | Buffer base address to load |
| clr_i | input | 1 | Clears interrupt and overrun flags |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | DATA_W | Memory write data |
| bd_upd_o | output | 1 | Descriptor close pulse |
| bd_upd_idx_o | output | IDX_W | Index of the closed descriptor |
| bd_upd_cnt_o | output | LEN_W+1 | Bytes received into the closed buffer |
| bd_upd_empty_o | output | 1 | Empty flag left in the closed descriptor |
| irq_o | output | 1 | Completion interrupt level |
| overrun_o | output | 1 | Sticky dropped-character flag |

## Verification
The hardest situation to reach is a character that meets a descriptor already used in an earlier lap, because it needs a full pass around the ring first. The stimulus loads all eight descriptors with short lengths and then sends back-to-back bursts until the index wraps to descriptor 0. There it finds a closed buffer, which shows both the drop and that the continuous descriptor was kept. The host then reloads the blocking descriptor and sends a close in the same cycle as a clear. This checks that the reload takes effect and that a new interrupt takes priority over the clear.

// File: rtl/rx_bd_pkg.sv
package rx_bd_pkg;
  localparam int LEN_W  = 8;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic              empty;
    logic              int_en;
    logic              cont;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  rcnt;
  } bd_t;
endpackage

// File: rtl/rx_bd_table.sv
module rx_bd_table
  import rx_bd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int IDX_W  = $clog2(NUM_BD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic              host_empty_i,
  input  logic              host_int_i,
  input  logic              host_cont_i,
  input  logic [LEN_W-1:0]  host_len_i,
  input  logic [ADDR_W-1:0] host_base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              acc_i,
  input  logic              close_i,
  output bd_t               cur_o
);
  logic [NUM_BD-1:0] empty_q, int_q, cont_q;
  logic [LEN_W-1:0]  len_q  [NUM_BD];
  logic [ADDR_W-1:0] base_q [NUM_BD];
  logic [LEN_W-1:0]  rcnt_q [NUM_BD];

  for (genvar i = 0; i < NUM_BD; i++) begin : g_bd
    logic host_hit, eng_hit;
    assign host_hit = host_we_i && (host_idx_i == IDX_W'(i));
    assign eng_hit  = acc_i && (idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        empty_q[i] <= 1'b0;
        int_q[i]   <= 1'b0;
        cont_q[i]  <= 1'b0;
        len_q[i]   <= '0;
        base_q[i]  <= '0;
        rcnt_q[i]  <= '0;
      end else if (host_hit) begin
        empty_q[i] <= host_empty_i;
        int_q[i]   <= host_int_i;
        cont_q[i]  <= host_cont_i;
        len_q[i]   <= host_len_i;
        base_q[i]  <= host_base_i;
        rcnt_q[i]  <= '0;
      end else if (eng_hit) begin
        if (close_i) begin
          rcnt_q[i] <= '0;
          if (!cont_q[i]) empty_q[i] <= 1'b0;
        end else begin
          rcnt_q[i] <= rcnt_q[i] + LEN_W'(1);
        end
      end
    end

    p_close_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eng_hit && close_i && !cont_q[i] && !host_hit) |=> !empty_q[i]);
    p_cont_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eng_hit && close_i && cont_q[i] && !host_hit) |=> empty_q[i] && (rcnt_q[i] == '0));
  end

  always_comb begin
    cur_o.empty  = empty_q[idx_i];
    cur_o.int_en = int_q[idx_i];
    cur_o.cont   = cont_q[idx_i];
    cur_o.len    = len_q[idx_i];
    cur_o.base   = base_q[idx_i];
    cur_o.rcnt   = rcnt_q[idx_i];
  end
endmodule

// File: rtl/rx_bd_fill.sv
module rx_bd_fill
  import rx_bd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(NUM_BD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  bd_t               cur_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              acc_o,
  output logic              close_o,
  output logic              drop_o,
  output logic              irq_set_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              upd_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic [LEN_W:0]    upd_cnt_o,
  output logic              upd_empty_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BD - 1);

  logic [IDX_W-1:0] idx_q, idx_nxt;

  assign acc_o     = rx_valid_i && cur_i.empty;
  assign drop_o    = rx_valid_i && !cur_i.empty;
  assign close_o   = acc_o && (cur_i.rcnt == cur_i.len - LEN_W'(1));
  assign irq_set_o = close_o && cur_i.int_en;
  assign idx_nxt   = (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      upd_o       <= 1'b0;
      upd_idx_o   <= '0;
      upd_cnt_o   <= '0;
      upd_empty_o <= 1'b0;
    end else begin
      mem_we_o <= acc_o;
      upd_o    <= close_o;
      if (acc_o) begin
        mem_addr_o <= cur_i.base + ADDR_W'(cur_i.rcnt);
        mem_data_o <= rx_data_i;
      end
      if (close_o) begin
        idx_q       <= idx_nxt;
        upd_idx_o   <= idx_q;
        upd_cnt_o   <= {1'b0, cur_i.rcnt} + (LEN_W+1)'(1);
        upd_empty_o <= cur_i.cont;
      end
    end
  end

  p_write_follows_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(rx_valid_i));
  p_drop_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !mem_we_o && !upd_o && (idx_q == $past(idx_q)));
  p_advance_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> (idx_q != $past(idx_q)) && upd_o);
  p_upd_with_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> mem_we_o);
endmodule

// File: rtl/rx_bd_irq.sv
module rx_bd_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_set_i,
  input  logic drop_i,
  input  logic clr_i,
  output logic irq_o,
  output logic overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      irq_o     <= irq_set_i | (irq_o & ~clr_i);
      overrun_o <= drop_i | (overrun_o & ~clr_i);
    end
  end

  p_irq_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_o);
  p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clr_i) |=> overrun_o);
endmodule

// File: rtl/rx_bd_seq.sv
module rx_bd_seq
  import rx_bd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(NUM_BD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic              host_empty_i,
  input  logic              host_int_i,
  input  logic              host_cont_i,
  input  logic [LEN_W-1:0]  host_len_i,
  input  logic [ADDR_W-1:0] host_base_i,
  input  logic              clr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              bd_upd_o,
  output logic [IDX_W-1:0]  bd_upd_idx_o,
  output logic [LEN_W:0]    bd_upd_cnt_o,
  output logic              bd_upd_empty_o,
  output logic              irq_o,
  output logic              overrun_o
);
  bd_t              cur;
  logic [IDX_W-1:0] idx;
  logic             acc, close, drop, irq_set;

  rx_bd_table #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni, .host_we_i, .host_idx_i, .host_empty_i, .host_int_i,
    .host_cont_i, .host_len_i, .host_base_i,
    .idx_i(idx), .acc_i(acc), .close_i(close), .cur_o(cur)
  );

  rx_bd_fill #(.NUM_BD(NUM_BD), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fill (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .cur_i(cur),
    .idx_o(idx), .acc_o(acc), .close_o(close), .drop_o(drop), .irq_set_o(irq_set),
    .mem_we_o, .mem_addr_o, .mem_data_o,
    .upd_o(bd_upd_o), .upd_idx_o(bd_upd_idx_o), .upd_cnt_o(bd_upd_cnt_o),
    .upd_empty_o(bd_upd_empty_o)
  );

  rx_bd_irq u_irq (
    .clk_i, .rst_ni, .irq_set_i(irq_set), .drop_i(drop), .clr_i,
    .irq_o, .overrun_o
  );
endmodule

// File: tb/tb_rx_bd_seq.sv
module tb_rx_bd_seq;
  import rx_bd_pkg::*;
  localparam int NUM_BD = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, host_we = 1'b0, h_empty = 1'b0, h_int = 1'b0, h_cont = 1'b0, clr = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic [IDX_W-1:0]  h_idx = '0;
  logic [LEN_W-1:0]  h_len = '0;
  logic [ADDR_W-1:0] h_base = '0;
  logic mem_we, bd_upd, bd_upd_empty, irq, ovr;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic [IDX_W-1:0]  bd_upd_idx;
  logic [LEN_W:0]    bd_upd_cnt;

  always #2 clk = ~clk;

  rx_bd_seq #(.NUM_BD(NUM_BD), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .host_we_i(host_we), .host_idx_i(h_idx), .host_empty_i(h_empty), .host_int_i(h_int),
    .host_cont_i(h_cont), .host_len_i(h_len), .host_base_i(h_base), .clr_i(clr),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .bd_upd_o(bd_upd), .bd_upd_idx_o(bd_upd_idx), .bd_upd_cnt_o(bd_upd_cnt),
    .bd_upd_empty_o(bd_upd_empty), .irq_o(irq), .overrun_o(ovr)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  bit               m_empty [NUM_BD], m_int [NUM_BD], m_cont [NUM_BD];
  int               m_len [NUM_BD], m_base [NUM_BD], m_cnt [NUM_BD];
  int               m_idx = 0;
  bit               exp_irq = 0, exp_ovr = 0;
  logic [ADDR_W+DATA_W-1:0]   mem_q [$];
  logic [IDX_W+LEN_W+1:0]     upd_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_bd(input int i, input bit e, input bit it, input bit c,
                         input int len, input int base);
    @(negedge clk);
    host_we = 1; h_idx = IDX_W'(i); h_empty = e; h_int = it; h_cont = c;
    h_len = LEN_W'(len); h_base = ADDR_W'(base);
    m_empty[i] = e; m_int[i] = it; m_cont[i] = c; m_len[i] = len; m_base[i] = base; m_cnt[i] = 0;
    @(negedge clk);
    host_we = 0;
  endtask

  // model one character in the current cycle
  task automatic model_char(input logic [DATA_W-1:0] d, input bit c);
    if (c) begin exp_irq = 0; exp_ovr = 0; end
    if (m_empty[m_idx]) begin
      mem_q.push_back({ADDR_W'(m_base[m_idx] + m_cnt[m_idx]), d});
      m_cnt[m_idx]++;
      if (m_cnt[m_idx] == m_len[m_idx]) begin
        upd_q.push_back({IDX_W'(m_idx), (LEN_W+1)'(m_len[m_idx]), m_cont[m_idx]});
        if (m_int[m_idx]) exp_irq = 1;
        if (!m_cont[m_idx]) m_empty[m_idx] = 0;
        m_cnt[m_idx] = 0;
        m_idx = (m_idx + 1) % NUM_BD;
      end
    end else begin
      exp_ovr = 1;
    end
  endtask

  task automatic flags(input string tag);
    chk(irq == exp_irq, {tag, " R3 irq"}, irq, exp_irq);
    chk(ovr == exp_ovr, {tag, " R6 overrun"}, ovr, exp_ovr);
  endtask

  task automatic send(input logic [DATA_W-1:0] d, input bit c, input string tag);
    @(negedge clk);
    rx_valid = 1; rx_data = d; clr = c;
    model_char(d, c);
    @(negedge clk);
    rx_valid = 0; clr = 0;
    flags(tag);
  endtask

  task automatic burst(input int n, input logic [DATA_W-1:0] d0, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = d0 + DATA_W'(k);
      model_char(d0 + DATA_W'(k), 0);
    end
    @(negedge clk);
    rx_valid = 0;
    flags(tag);
  endtask

  task automatic do_clr(input string tag);
    @(negedge clk); clr = 1; exp_irq = 0; exp_ovr = 0;
    @(negedge clk); clr = 0;
    flags(tag);
  endtask

  // monitor: outputs are compared with the queued expectations
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (mem_q.size() == 0) chk(0, "R6 unexpected write", mem_addr, 0);
        else begin
          logic [ADDR_W+DATA_W-1:0] e;
          e = mem_q.pop_front();
          chk({mem_addr, mem_data} == e, "R1 write addr/data", {mem_addr, mem_data}, e);
        end
      end
      if (bd_upd) begin
        if (upd_q.size() == 0) chk(0, "R2 unexpected update", bd_upd_idx, 0);
        else begin
          logic [IDX_W+LEN_W+1:0] e;
          e = upd_q.pop_front();
          chk({bd_upd_idx, bd_upd_cnt, bd_upd_empty} == e, "R2/R5 update idx/cnt/empty",
              {bd_upd_idx, bd_upd_cnt, bd_upd_empty}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_BD; i++) begin
      m_empty[i] = 0; m_int[i] = 0; m_cont[i] = 0; m_len[i] = 0; m_base[i] = 0; m_cnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!mem_we && !bd_upd && !irq && !ovr, "R8 reset outputs", {mem_we, bd_upd, irq, ovr}, 0);
    rst_n = 1;
    @(negedge clk);
    // R8: descriptors start not empty, so a char is dropped (R6)
    send(8'h11, 0, "R8 drop after reset");
    do_clr("R9 clear overrun");
    // R7 loads
    load_bd(0, 1, 1, 0, 3, 'h100);
    load_bd(1, 1, 0, 0, 2, 'h200);
    load_bd(2, 1, 1, 1, 2, 'h300);
    for (int i = 3; i < NUM_BD; i++) load_bd(i, 1, 0, 0, 1, 'h400 + i * 16);
    // R1, R2, R3 on descriptor 0
    send(8'hA0, 0, "R1 bd0 c0");
    send(8'hA1, 0, "R1 bd0 c1");
    send(8'hA2, 0, "R2 bd0 close");
    // R3 level holds while bd1 (no int) fills, R4 back-to-back
    burst(2, 8'hB0, "R3 hold bd1");
    do_clr("R3 clear irq");
    // R5 continuous descriptor
    burst(2, 8'hC0, "R5 bd2 cont");
    do_clr("R3 clear again");
    // R4 back-to-back through 3..7 and wrap to 0, where bd0 is now not empty (R6)
    burst(6, 8'hD0, "R4 wrap drop");
    chk(mem_q.size() == 0, "R6 no pending write", mem_q.size(), 0);
    do_clr("R9 clear after wrap");
    // R7 reload bd0, then R6 drop at bd1
    load_bd(0, 1, 0, 0, 1, 'h180);
    send(8'hE0, 0, "R7 reloaded bd0");
    send(8'hE1, 0, "R6 bd1 full drop");
    // R9 set wins over clear in the same cycle
    load_bd(1, 1, 1, 0, 1, 'h280);
    send(8'hE2, 1, "R9 set wins");
    // R5 second lap into the continuous buffer
    send(8'hF0, 0, "R5 lap2 c0");
    send(8'hF1, 0, "R5 lap2 close");
    repeat (3) @(negedge clk);
    chk(mem_q.size() == 0, "R1 all writes seen", mem_q.size(), 0);
    chk(upd_q.size() == 0, "R2 all updates seen", upd_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule